// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on the 8-bit data, 16-bit address bus of a small CPU and steers each access to an external ROM of up to 2 MB or to an external battery-less RAM of up to 128 KB. Writes that fall in the lower 32 KB of the address space never reach the ROM. Their address range selects one of four control fields instead: a RAM gate, a 5-bit low bank number, a 2-bit high bank field and a mapping mode.

Reads in the lower half are translated into a 21-bit physical ROM address. Accesses to the 8 KB window at 0xA000 become a 17-bit physical RAM address. Two size-code inputs give the installed ROM and RAM capacity, and every physical address wraps to that capacity. When RAM is gated off or not fitted, RAM-window reads return 0xFF and RAM-window writes have no effect.

All select, strobe and address outputs are registered, so they appear one clock after the bus cycle that requested them. The read data mux follows that registered state.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with an address in 0x0000–0x1FFF turns the RAM gate on if data bits [3:0] equal 0xA. Any other value turns the gate off.
- R2: A write in 0x2000–0x3FFF loads data bits [4:0] into the low bank number. A value of 0 is stored as 1, so the low bank number is never 0.
- R3: A write in 0x4000–0x5FFF loads data bits [1:0] into the high bank field.
- R4: A write in 0x6000–0x7FFF sets the mode from data bit 0: 0 is simple and 1 is advanced.
- R5: A read in 0x4000–0x7FFF produces rom_addr = (bank_lo + 32·bank_hi)·16384 + (addr − 0x4000), before wrapping.
- R6: A read in 0x0000–0x3FFF produces rom_addr = addr in simple mode, and 32·bank_hi·16384 + addr in advanced mode, before wrapping.
- R7: The ROM bank index wraps to the installed size. For codes 0x00–0x08 the size is 2<<code banks, capped at 128. Codes 0x52, 0x53 and 0x54 give 72, 80 and 96 banks. Any other code is treated as 128 banks.
- R8: A RAM-window access (0xA000–0xBFFF) produces ram_addr = bank·8192 + (addr − 0xA000), where bank is bank_hi in advanced mode and 0 in simple mode. The result is wrapped modulo the RAM size. RAM codes are 1=2 KB, 2=8 KB, 3=32 KB, 4=128 KB and 5=64 KB; every other code means no RAM.
- R9: If the RAM gate is off or no RAM is fitted, a RAM-window read returns 0xFF on bus_rdata, and a RAM-window access raises none of ram_cs, ram_rd or ram_wr. Otherwise a read raises ram_cs with ram_rd, and a write raises ram_cs with ram_wr and presents the data on ram_wdata.
- R10: After reset the low bank number is 1, the RAM gate is off, the high field is 0, the mode is simple and no select is active.
- R11: Accesses in 0x8000–0x9FFF and 0xC000–0xFFFF raise no select, and writes there change no control field.
- R12: Outputs follow the bus cycle by exactly one clock. A control write raises no ROM select, and it takes effect for an access presented in the very next cycle. If rd and wr are both high, the cycle is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | CPU read request for this cycle |
| bus_wr | input | 1 | CPU write request for this cycle |
| rom_size_code | input | 8 | Installed ROM size code |
| ram_size_code | input | 8 | Installed RAM size code |
| ext_rdata | input | 8 | Data returned by the external ROM/RAM |
| bus_rdata | output | 8 | Read data to the CPU (0xFF for a gated RAM read) |
| rom_cs | output | 1 | Registered ROM chip select |
| rom_addr | output | 21 | Registered physical ROM address |
| ram_cs | output | 1 | Registered RAM chip select |
| ram_rd | output | 1 | Registered RAM read strobe |
| ram_wr | output | 1 | Registered RAM write strobe |
| ram_addr | output | 17 | Registered physical RAM address |
| ram_wdata | output | 8 | Registered RAM write data |

## Verification
The interaction most likely to break is a control-register update followed at once by an address translation that depends on it. The bench writes a bank number in one cycle and presents a ROM read in the very next cycle, with no idle cycle between them. It then checks that the registered ROM address already carries the new bank. It also checks that the write cycle itself left the ROM select low. The same pairing is exercised for the RAM gate: a disabling write followed by a RAM-window read must give 0xFF and no RAM strobe.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int ROM_OFS_W = 14;
  localparam int RAM_OFS_W = 13;
  localparam int LO_W      = 5;
  localparam int HI_W      = 2;
  localparam int BANK_W    = LO_W + HI_W;
  localparam int ROM_AW    = ROM_OFS_W + BANK_W;
  localparam int RAM_AW    = 17;

  typedef enum logic {MODE_SIMPLE = 1'b0, MODE_ADV = 1'b1} bank_mode_e;

  typedef struct packed {
    logic              ram_on;
    logic [LO_W-1:0]   lo;
    logic [HI_W-1:0]   hi;
    bank_mode_e        mode;
  } bank_cfg_t;

  // Wrap a 7-bit ROM bank index to the number of installed banks.
  function automatic logic [BANK_W-1:0] wrap_rom_bank(input logic [BANK_W-1:0] b,
                                                      input logic [7:0] code);
    logic [BANK_W-1:0] r;
    r = b;
    if (code <= 8'h08)
      r = b & BANK_W'((32'd2 << code) - 32'd1);
    else if (code == 8'h52)
      r = (b >= BANK_W'(72)) ? b - BANK_W'(72) : b;
    else if (code == 8'h53)
      r = (b >= BANK_W'(80)) ? b - BANK_W'(80) : b;
    else if (code == 8'h54)
      r = (b >= BANK_W'(96)) ? b - BANK_W'(96) : b;
    return r;
  endfunction

  function automatic logic ram_fitted(input logic [7:0] code);
    return (code >= 8'h01) && (code <= 8'h05);
  endfunction

  function automatic logic [RAM_AW-1:0] ram_wrap_mask(input logic [7:0] code);
    logic [RAM_AW-1:0] m;
    case (code)
      8'h01:   m = RAM_AW'(17'h007FF);
      8'h02:   m = RAM_AW'(17'h01FFF);
      8'h03:   m = RAM_AW'(17'h07FFF);
      8'h04:   m = RAM_AW'(17'h1FFFF);
      8'h05:   m = RAM_AW'(17'h0FFFF);
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cart_cfg_regs.sv
module cart_cfg_regs
  import cart_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  field_sel,
  input  logic [7:0]  wdata,
  output bank_cfg_t   cfg
);
  logic            hit_gate, hit_lo, hit_hi, hit_mode;
  logic [LO_W-1:0] lo_next;

  assign hit_gate = wr_en && (field_sel == 2'd0);
  assign hit_lo   = wr_en && (field_sel == 2'd1);
  assign hit_hi   = wr_en && (field_sel == 2'd2);
  assign hit_mode = wr_en && (field_sel == 2'd3);
  assign lo_next  = (wdata[LO_W-1:0] == '0) ? LO_W'(1) : wdata[LO_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.ram_on <= 1'b0;
      cfg.lo     <= LO_W'(1);
      cfg.hi     <= '0;
      cfg.mode   <= MODE_SIMPLE;
    end else begin
      if (hit_gate) cfg.ram_on <= (wdata[3:0] == 4'hA);
      if (hit_lo)   cfg.lo     <= lo_next;
      if (hit_hi)   cfg.hi     <= wdata[HI_W-1:0];
      if (hit_mode) cfg.mode   <= bank_mode_e'(wdata[0]);
    end
  end
endmodule

// File: rtl/cart_rom_xlat.sv
module cart_rom_xlat
  import cart_bank_pkg::*;
(
  input  logic                 upper_win,
  input  logic [ROM_OFS_W-1:0] offset,
  input  logic [LO_W-1:0]      lo,
  input  logic [HI_W-1:0]      hi,
  input  bank_mode_e           mode,
  input  logic [7:0]           size_code,
  output logic [ROM_AW-1:0]    phys
);
  logic [BANK_W-1:0] raw_bank;
  logic [BANK_W-1:0] eff_bank;

  always_comb begin
    if (upper_win)
      raw_bank = {hi, lo};
    else if (mode == MODE_ADV)
      raw_bank = {hi, LO_W'(0)};
    else
      raw_bank = '0;
  end

  assign eff_bank = wrap_rom_bank(raw_bank, size_code);
  assign phys     = {eff_bank, offset};
endmodule

// File: rtl/cart_ram_xlat.sv
module cart_ram_xlat
  import cart_bank_pkg::*;
(
  input  logic [RAM_OFS_W-1:0] offset,
  input  logic [HI_W-1:0]      hi,
  input  bank_mode_e           mode,
  input  logic [7:0]           size_code,
  output logic [RAM_AW-1:0]    phys,
  output logic                 fitted
);
  localparam int RAW_W = RAM_OFS_W + HI_W;
  logic [HI_W-1:0]  bank;
  logic [RAW_W-1:0] raw;

  assign bank   = (mode == MODE_ADV) ? hi : '0;
  assign raw    = {bank, offset};
  assign phys   = RAM_AW'(raw) & ram_wrap_mask(size_code);
  assign fitted = ram_fitted(size_code);
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        rom_size_code,
  input  logic [7:0]        ram_size_code,
  input  logic [7:0]        ext_rdata,
  output logic [7:0]        bus_rdata,
  output logic              rom_cs,
  output logic [20:0]       rom_addr,
  output logic              ram_cs,
  output logic              ram_rd,
  output logic              ram_wr,
  output logic [16:0]       ram_addr,
  output logic [7:0]        ram_wdata
);
  bank_cfg_t          cfg;
  logic               in_rom_win, in_ram_win;
  logic               rd_eff, cfg_wr;
  logic               ram_fit, ram_open;
  logic [ROM_AW-1:0]  rom_phys;
  logic [RAM_AW-1:0]  ram_phys;
  logic               float_q;

  // named internal events for the checker
  logic               cfg_ram_on;
  logic [LO_W-1:0]    cfg_bank_lo;

  assign in_rom_win  = ~bus_addr[15];
  assign in_ram_win  = (bus_addr[15:13] == 3'b101);
  assign rd_eff      = bus_rd & ~bus_wr;
  assign cfg_wr      = bus_wr & in_rom_win;
  assign cfg_ram_on  = cfg.ram_on;
  assign cfg_bank_lo = cfg.lo;
  assign ram_open    = in_ram_win & cfg.ram_on & ram_fit;

  cart_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .field_sel (bus_addr[14:13]),
    .wdata     (bus_wdata),
    .cfg       (cfg)
  );

  cart_rom_xlat u_rom (
    .upper_win (bus_addr[14]),
    .offset    (bus_addr[ROM_OFS_W-1:0]),
    .lo        (cfg.lo),
    .hi        (cfg.hi),
    .mode      (cfg.mode),
    .size_code (rom_size_code),
    .phys      (rom_phys)
  );

  cart_ram_xlat u_ram (
    .offset    (bus_addr[RAM_OFS_W-1:0]),
    .hi        (cfg.hi),
    .mode      (cfg.mode),
    .size_code (ram_size_code),
    .phys      (ram_phys),
    .fitted    (ram_fit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_cs    <= 1'b0;
      rom_addr  <= '0;
      ram_cs    <= 1'b0;
      ram_rd    <= 1'b0;
      ram_wr    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      float_q   <= 1'b0;
    end else begin
      rom_cs    <= rd_eff & in_rom_win;
      rom_addr  <= rom_phys;
      ram_cs    <= (rd_eff | bus_wr) & ram_open;
      ram_rd    <= rd_eff & ram_open;
      ram_wr    <= bus_wr & ram_open;
      ram_addr  <= ram_phys;
      ram_wdata <= bus_wdata;
      float_q   <= rd_eff & in_ram_win & ~ram_open;
    end
  end

  assign bus_rdata = float_q ? 8'hFF : ext_rdata;
endmodule

// File: rtl/cart_bank_chk.sv
module cart_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_rdata,
  input logic        rom_cs,
  input logic        ram_cs,
  input logic        ram_rd,
  input logic        ram_wr,
  input logic        cfg_ram_on,
  input logic [4:0]  cfg_bank_lo
);
  // R2
  bank_lo_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bank_lo != 5'd0);

  // R1
  ram_gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b000 && bus_wdata[3:0] == 4'hA) |=> cfg_ram_on);

  // R1
  ram_gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b000 && bus_wdata[3:0] != 4'hA) |=> !cfg_ram_on);

  // R9
  ram_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> $past(cfg_ram_on));

  // R9
  float_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr[15:13] == 3'b101 && !cfg_ram_on)
      |=> (bus_rdata == 8'hFF && !ram_cs && !ram_rd));

  // R9
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd || ram_wr) |-> ram_cs);

  // R11
  no_sel_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_addr[15] && bus_addr[15:13] != 3'b101)
      |=> (!rom_cs && !ram_cs));

  // R12
  wr_no_rom_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !rom_cs);

  // R12
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs}));
endmodule

bind cart_bank_ctrl cart_bank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_rdata   (bus_rdata),
  .rom_cs      (rom_cs),
  .ram_cs      (ram_cs),
  .ram_rd      (ram_rd),
  .ram_wr      (ram_wr),
  .cfg_ram_on  (cfg_ram_on),
  .cfg_bank_lo (cfg_bank_lo)
);

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  rom_size_code = 8'h07, ram_size_code = 8'h03;
  logic [7:0]  ext_rdata = 8'h5A;
  logic [7:0]  bus_rdata;
  logic        rom_cs, ram_cs, ram_rd, ram_wr;
  logic [20:0] rom_addr;
  logic [16:0] ram_addr;
  logic [7:0]  ram_wdata;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  cart_bank_ctrl u0 (.*);

  initial forever #5 clk = ~clk;

  // Independent model of the ROM translation
  function automatic int rom_banks(input logic [7:0] c);
    if (c <= 8'h08) return (2 << c) > 128 ? 128 : (2 << c);
    if (c == 8'h52) return 72;
    if (c == 8'h53) return 80;
    if (c == 8'h54) return 96;
    return 128;
  endfunction

  function automatic int exp_rom(input int bank, input int ofs, input logic [7:0] c);
    return (bank % rom_banks(c)) * 16384 + ofs;
  endfunction

  function automatic int exp_ram(input int bank, input int ofs, input logic [7:0] c);
    int sz;
    case (c)
      8'h01: sz = 2048;
      8'h02: sz = 8192;
      8'h03: sz = 32768;
      8'h04: sz = 131072;
      default: sz = 65536;
    endcase
    return (bank * 8192 + ofs) % sz;
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive one bus cycle starting at a falling edge; returns at the next falling edge,
  // when the registered result of that cycle is visible.
  task automatic bus_cycle(input bit rd, input bit wr, input logic [15:0] a, input logic [7:0] d);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    bus_cycle(1'b0, 1'b1, a, d);
  endtask

  task automatic do_rd(input logic [15:0] a);
    bus_cycle(1'b1, 1'b0, a, 8'h00);
  endtask

  task automatic rom_read_chk(input string req, input logic [15:0] a, input int exp);
    do_rd(a);
    check(req, rom_cs === 1'b1 && ram_cs === 1'b0, {rom_cs, ram_cs}, 2);
    check(req, rom_addr === 21'(exp), rom_addr, exp);
  endtask

  task automatic t_reset;
    check("R10 selects idle", rom_cs === 0 && ram_cs === 0 && ram_rd === 0 && ram_wr === 0,
          {rom_cs, ram_cs, ram_rd, ram_wr}, 0);
    rom_read_chk("R10 bank1", 16'h4000, 32'h4000);
    do_rd(16'hA000);
    check("R10 ram off", ram_cs === 0 && bus_rdata === 8'hFF, bus_rdata, 8'hFF);
  endtask

  task automatic t_gate;
    do_wr(16'h1234, 8'h3A);
    do_rd(16'hA010);
    check("R1 gate on", ram_cs === 1 && ram_rd === 1 && ram_addr === 17'h10, ram_addr, 17'h10);
    do_wr(16'h0000, 8'hA5);
    do_rd(16'hA010);
    check("R1 gate off", ram_cs === 0 && bus_rdata === 8'hFF, bus_rdata, 8'hFF);
  endtask

  task automatic t_lobank;
    do_wr(16'h2000, 8'h00);
    check("R12 wr no rom_cs", rom_cs === 0, rom_cs, 0);
    rom_read_chk("R2 zero->1", 16'h4001, exp_rom(1, 1, 8'h07));
    do_wr(16'h3FFF, 8'hE5);
    rom_read_chk("R2 five bits", 16'h7FFF, exp_rom(5, 16'h3FFF, 8'h07));
  endtask

  task automatic t_upper;
    do_wr(16'h4000, 8'hFE);
    rom_read_chk("R3 R5 upper", 16'h4000, exp_rom(5 + 64, 0, 8'h07));
    rom_read_chk("R6 simple low", 16'h0123, 32'h0123);
  endtask

  task automatic t_mode;
    do_wr(16'h6000, 8'h01);
    rom_read_chk("R4 R6 adv low", 16'h0123, exp_rom(64, 16'h123, 8'h07));
    do_wr(16'h7000, 8'hFE);
    rom_read_chk("R4 back simple", 16'h0123, 32'h0123);
  endtask

  task automatic t_wrap;
    do_wr(16'h2000, 8'h1F);
    rom_size_code = 8'h52;
    rom_read_chk("R7 72 banks", 16'h5000, exp_rom(95, 16'h1000, 8'h52));
    rom_size_code = 8'h53;
    rom_read_chk("R7 80 banks", 16'h5000, exp_rom(95, 16'h1000, 8'h53));
    rom_size_code = 8'h54;
    rom_read_chk("R7 96 banks", 16'h5000, exp_rom(95, 16'h1000, 8'h54));
    rom_size_code = 8'h02;
    rom_read_chk("R7 8 banks", 16'h5000, exp_rom(95, 16'h1000, 8'h02));
    rom_size_code = 8'h60;
    rom_read_chk("R7 unknown code", 16'h5000, exp_rom(95, 16'h1000, 8'h60));
    rom_size_code = 8'h07;
  endtask

  task automatic t_ram;
    do_wr(16'h0800, 8'h0A);
    do_wr(16'h6000, 8'h01);
    ram_size_code = 8'h03;
    do_rd(16'hA123);
    check("R8 adv bank", ram_cs === 1 && ram_addr === 17'(exp_ram(2, 16'h123, 8'h03)),
          ram_addr, exp_ram(2, 16'h123, 8'h03));
    ram_size_code = 8'h01;
    do_rd(16'hBFFF);
    check("R8 wrap 2K", ram_addr === 17'(exp_ram(2, 16'h1FFF, 8'h01)), ram_addr, exp_ram(2, 16'h1FFF, 8'h01));
    ram_size_code = 8'h04;
    do_rd(16'hBFFF);
    check("R8 128K", ram_addr === 17'(exp_ram(2, 16'h1FFF, 8'h04)), ram_addr, exp_ram(2, 16'h1FFF, 8'h04));
    do_wr(16'h6000, 8'h00);
    do_rd(16'hBFFF);
    check("R8 simple bank0", ram_addr === 17'(exp_ram(0, 16'h1FFF, 8'h04)), ram_addr, exp_ram(0, 16'h1FFF, 8'h04));
    do_wr(16'hA555, 8'h77);
    check("R9 ram write", ram_cs === 1 && ram_wr === 1 && ram_rd === 0 && ram_wdata === 8'h77
          && ram_addr === 17'h0555, ram_wdata, 8'h77);
  endtask

  task automatic t_absent;
    ram_size_code = 8'h00;
    do_rd(16'hA000);
    check("R9 absent read", ram_cs === 0 && bus_rdata === 8'hFF, bus_rdata, 8'hFF);
    do_wr(16'hA000, 8'h11);
    check("R9 absent write", ram_wr === 0 && ram_cs === 0, ram_wr, 0);
    ram_size_code = 8'h03;
    do_wr(16'h0000, 8'h00);
    do_wr(16'hA000, 8'h22);
    check("R9 gated write", ram_wr === 0 && ram_cs === 0, ram_wr, 0);
    do_rd(16'h4000);
    check("R9 rom data pass", bus_rdata === 8'h5A, bus_rdata, 8'h5A);
  endtask

  task automatic t_outside;
    do_rd(16'h8000);
    check("R11 0x8000", rom_cs === 0 && ram_cs === 0, {rom_cs, ram_cs}, 0);
    do_rd(16'hC000);
    check("R11 0xC000", rom_cs === 0 && ram_cs === 0, {rom_cs, ram_cs}, 0);
    do_wr(16'hC000, 8'h00);
    do_wr(16'h9FFF, 8'h0A);
    rom_read_chk("R11 bank kept", 16'h4000, exp_rom(31 + 64, 0, 8'h07));
    do_rd(16'hA000);
    check("R11 gate kept", ram_cs === 0 && bus_rdata === 8'hFF, bus_rdata, 8'hFF);
  endtask

  task automatic t_b2b;
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = 16'h2000; bus_wdata = 8'h03;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 16'h4000;
    check("R12 write cycle no rom_cs", rom_cs === 0, rom_cs, 0);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R12 next-cycle bank", rom_cs === 1 && rom_addr === 21'(exp_rom(3 + 64, 0, 8'h07)),
          rom_addr, exp_rom(3 + 64, 0, 8'h07));
    bus_cycle(1'b1, 1'b1, 16'hA000, 8'h44);
    check("R12 rd+wr is write", rom_cs === 0 && ram_cs === 0 && ram_rd === 0, {rom_cs, ram_rd}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_lobank();
    t_upper();
    t_mode();
    t_wrap();
    t_ram();
    t_absent();
    t_outside();
    t_b2b();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule